// File: doc/BRIEF.md
# Two-Manager Snooping Coherent Interconnect

This block sits between two caching managers and a small backing store. Each manager can ask for a shared copy of a line (read-shared) or for sole ownership of a line (make-unique). For shareable requests the interconnect snoops the other manager: a read snoop for a read-shared request, an invalidating snoop for a make-unique request. It then merges the snoop response into a single response to the requester. Read data comes from the snooped cache when that cache holds the line. Otherwise it comes from the backing store.

Ordering is enforced per line. A shareable transaction stays tracked after its response has been sent, and stays tracked until its initiator acknowledges it: a write acknowledge for make-unique, a read acknowledge for read-shared. While the line is tracked, any later request to the same address is held off. Requests whose domain field marks them non-shareable skip snooping and read the backing store directly. They may proceed to other addresses while an acknowledge is still pending.

Top module: `coh_ic`

## Requirements
- R1: After reset no `req_ready`, `rsp_valid` or `snp_valid` bit is high, and backing-store word `a` holds `MEM_BASE + a`.
- R2: A shareable make-unique (`req_op` = 1) sends a snoop with `snp_op` = 1 and the request address to the other manager. The response (data 0, resp 4'b0000) comes only in the cycle after that manager's snoop response.
- R3: A shareable read-shared (`req_op` = 0) sends a snoop with `snp_op` = 0 and the request address to the other manager.
- R4: When the snoop response has `cr_has_data` = 1, the reader receives `cd_data`. In that response, resp bit 2 (shared) = 1 and resp bit 3 (passes dirty) = `cr_dirty`, while bits 1:0 = 0. Bit 3 is never set without bit 2.
- R5: When the snoop response has `cr_has_data` = 0, the reader receives the backing-store word with resp 4'b0000.
- R6: A request with domain 2'b00 is non-shareable: no snoop is issued and the response comes the cycle after acceptance with resp 4'b0000. Its data is the store word for read-shared and 0 for make-unique. Every other domain value is shareable.
- R7: A request to the address of a tracked transaction is not accepted until that transaction has sent its response and its initiator has asserted the matching acknowledge: `wack` for make-unique, `rack` for read-shared. An acknowledge of the wrong kind, or from the other manager, leaves the request stalled.
- R8: Only one shareable transaction is tracked at a time, so a shareable request to any address waits while one is tracked. Non-shareable requests to other addresses are still served.
- R9: When both managers are eligible, one is granted. Priority starts at manager 0 after reset and passes to the manager not served after every response. `req_ready` is high only with `req_valid`.
- R10: Dirty data forwarded between managers is not written into the backing store.
- R11: A snoop request holds `snp_valid`, `snp_op` and `snp_addr` stable until `snp_ready`. At most one bit of `snp_valid` and at most one bit of `rsp_valid` is high in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request valid, one bit per manager |
| req_ready | output | 2 | Request accepted, one bit per manager |
| req_op | input | 2 | Per manager: 0 read-shared, 1 make-unique |
| req_dom | input | 2x2 | Per manager domain field, 2'b00 non-shareable |
| req_addr | input | 2xAW | Per manager line address |
| rsp_valid | output | 2 | One-cycle response strobe to the requester |
| rsp_data | output | DW | Response data |
| rsp_resp | output | 4 | Response code, bit 2 shared, bit 3 passes dirty |
| rack | input | 2 | Read acknowledge from each manager |
| wack | input | 2 | Write acknowledge from each manager |
| snp_valid | output | 2 | Snoop request to each manager |
| snp_ready | input | 2 | Snoop request taken by each manager |
| snp_op | output | 1 | Snoop kind: 0 read, 1 invalidate |
| snp_addr | output | AW | Snoop address |
| cr_valid | input | 2 | Snoop response valid from each manager |
| cr_has_data | input | 2 | Snooped cache supplies the line |
| cr_dirty | input | 2 | Supplied line is dirty |
| cd_data | input | 2xDW | Snoop data from each manager |

## Verification
On every cycle, the assertions check that a grant never lands on a tracked line and never lands on a shareable request while a line is tracked. They also check that grants, snoops and responses stay one-hot, that a waiting snoop holds its fields steady, and that the dirty-passing bit never appears without the shared bit. Only the bench scenarios show the rest. These are the data path choice between snoop data and the store, the exact response codes and snoop kinds, the release of a stalled request by the correct acknowledge only, the rotation of priority, and the store keeping its old word after dirty data has been forwarded.

// File: rtl/coh_pkg.sv
package coh_pkg;
    localparam logic       OP_RD_SHARED = 1'b0;
    localparam logic       OP_MK_UNIQUE = 1'b1;
    localparam logic [1:0] DOM_PRIVATE  = 2'b00;
    localparam int         RESP_W       = 4;
    localparam int         RESP_SHR_BIT = 2;
    localparam int         RESP_DRT_BIT = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SNP_REQ = 2'd1,
        ST_SNP_RSP = 2'd2
    } seq_st_e;
endpackage

// File: rtl/coh_arb.sv
module coh_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] elig,
    input  logic       adv,
    input  logic       served,
    output logic [1:0] gnt
);
    typedef struct packed {
        logic prio;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        arb_d = arb_q;
        gnt   = 2'b00;
        if (elig[arb_q.prio]) begin
            gnt[arb_q.prio] = 1'b1;
        end else if (elig[~arb_q.prio]) begin
            gnt[~arb_q.prio] = 1'b1;
        end
        if (adv) begin
            arb_d.prio = ~served;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q <= '0;
        end else begin
            arb_q <= arb_d;
        end
    end
endmodule

// File: rtl/coh_trk.sv
module coh_trk #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic [AW-1:0] set_addr,
    input  logic          set_owner,
    input  logic          set_kind,
    input  logic          sent,
    input  logic [1:0]    rack,
    input  logic [1:0]    wack,
    output logic          busy,
    output logic [AW-1:0] line
);
    typedef struct packed {
        logic          valid;
        logic          owner;
        logic          kind;
        logic          sent;
        logic [AW-1:0] addr;
    } trk_t;

    trk_t trk_d, trk_q;
    logic ack_hit;

    always_comb begin
        trk_d   = trk_q;
        ack_hit = trk_q.kind ? wack[trk_q.owner] : rack[trk_q.owner];
        if (trk_q.valid && trk_q.sent && ack_hit) begin
            trk_d.valid = 1'b0;
            trk_d.sent  = 1'b0;
        end
        if (sent) begin
            trk_d.sent = 1'b1;
        end
        if (set) begin
            trk_d.valid = 1'b1;
            trk_d.owner = set_owner;
            trk_d.kind  = set_kind;
            trk_d.sent  = 1'b0;
            trk_d.addr  = set_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign busy = trk_q.valid;
    assign line = trk_q.addr;
endmodule

// File: rtl/coh_mem.sv
module coh_mem #(
    parameter int            AW   = 4,
    parameter int            DW   = 32,
    parameter logic [DW-1:0] BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= BASE + DW'(i);
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/coh_ic.sv
module coh_ic
    import coh_pkg::*;
#(
    parameter int            AW       = 4,
    parameter int            DW       = 32,
    parameter logic [DW-1:0] MEM_BASE = 32'hA5A5_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            req_valid,
    output logic [1:0]            req_ready,
    input  logic [1:0]            req_op,
    input  logic [1:0][1:0]       req_dom,
    input  logic [1:0][AW-1:0]    req_addr,
    output logic [1:0]            rsp_valid,
    output logic [DW-1:0]         rsp_data,
    output logic [RESP_W-1:0]     rsp_resp,
    input  logic [1:0]            rack,
    input  logic [1:0]            wack,
    output logic [1:0]            snp_valid,
    input  logic [1:0]            snp_ready,
    output logic                  snp_op,
    output logic [AW-1:0]         snp_addr,
    input  logic [1:0]            cr_valid,
    input  logic [1:0]            cr_has_data,
    input  logic [1:0]            cr_dirty,
    input  logic [1:0][DW-1:0]    cd_data
);
    typedef struct packed {
        seq_st_e           st;
        logic              owner;
        logic              op;
        logic [AW-1:0]     addr;
        logic [1:0]        rsp_valid;
        logic [DW-1:0]     rsp_data;
        logic [RESP_W-1:0] rsp_resp;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [1:0]    elig;
    logic [1:0]    grant;
    logic          gsel;
    logic          oth;
    logic          done;
    logic          served;
    logic          trk_set;
    logic          trk_sent;
    logic          trk_valid;
    logic [AW-1:0] trk_addr;
    logic [AW-1:0] mem_raddr;
    logic [DW-1:0] mem_rdata;

    // eligibility: sequencer free, no line hazard, tracker free for shareable requests
    always_comb begin
        for (int m = 0; m < 2; m++) begin
            elig[m] = req_valid[m] && (ctl_q.st == ST_IDLE) &&
                      !(trk_valid && ((req_dom[m] != DOM_PRIVATE) ||
                                      (req_addr[m] == trk_addr)));
        end
    end

    coh_arb u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .elig   (elig),
        .adv    (done),
        .served (served),
        .gnt    (grant)
    );

    coh_trk #(.AW(AW)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (trk_set),
        .set_addr  (ctl_d.addr),
        .set_owner (ctl_d.owner),
        .set_kind  (ctl_d.op),
        .sent      (trk_sent),
        .rack      (rack),
        .wack      (wack),
        .busy      (trk_valid),
        .line      (trk_addr)
    );

    coh_mem #(.AW(AW), .DW(DW), .BASE(MEM_BASE)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign gsel      = grant[1];
    assign oth       = ~ctl_q.owner;
    assign mem_raddr = (ctl_q.st == ST_IDLE) ? req_addr[gsel] : ctl_q.addr;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 2'b00;
        snp_valid       = 2'b00;
        done            = 1'b0;
        served          = ctl_q.owner;
        trk_set         = 1'b0;
        trk_sent        = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (|grant) begin
                    ctl_d.owner = gsel;
                    ctl_d.op    = req_op[gsel];
                    ctl_d.addr  = req_addr[gsel];
                    served      = gsel;
                    if (req_dom[gsel] == DOM_PRIVATE) begin
                        ctl_d.rsp_valid[gsel] = 1'b1;
                        ctl_d.rsp_data = (req_op[gsel] == OP_MK_UNIQUE) ? '0 : mem_rdata;
                        ctl_d.rsp_resp = '0;
                        done           = 1'b1;
                    end else begin
                        ctl_d.st = ST_SNP_REQ;
                        trk_set  = 1'b1;
                    end
                end
            end
            ST_SNP_REQ: begin
                snp_valid[oth] = 1'b1;
                if (snp_ready[oth]) begin
                    ctl_d.st = ST_SNP_RSP;
                end
            end
            ST_SNP_RSP: begin
                if (cr_valid[oth]) begin
                    ctl_d.st                     = ST_IDLE;
                    ctl_d.rsp_valid[ctl_q.owner] = 1'b1;
                    ctl_d.rsp_resp               = '0;
                    done                         = 1'b1;
                    trk_sent                     = 1'b1;
                    if (ctl_q.op == OP_MK_UNIQUE) begin
                        ctl_d.rsp_data = '0;
                    end else if (cr_has_data[oth]) begin
                        ctl_d.rsp_data               = cd_data[oth];
                        ctl_d.rsp_resp[RESP_SHR_BIT] = 1'b1;
                        ctl_d.rsp_resp[RESP_DRT_BIT] = cr_dirty[oth];
                    end else begin
                        ctl_d.rsp_data = mem_rdata;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = grant;
    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_data  = ctl_q.rsp_data;
    assign rsp_resp  = ctl_q.rsp_resp;
    assign snp_op    = ctl_q.op;
    assign snp_addr  = ctl_q.addr;
endmodule

// File: rtl/coh_ic_chk.sv
module coh_ic_chk #(
    parameter int AW = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          req_valid,
    input logic [1:0]          req_ready,
    input logic [1:0][1:0]     req_dom,
    input logic [1:0][AW-1:0]  req_addr,
    input logic [1:0]          rsp_valid,
    input logic [3:0]          rsp_resp,
    input logic [1:0]          snp_valid,
    input logic [1:0]          snp_ready,
    input logic                snp_op,
    input logic [AW-1:0]       snp_addr,
    input logic                trk_valid,
    input logic [AW-1:0]       trk_addr
);
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready)); // R9
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == 2'b00); // R9
    AST_NO_HAZARD_GRANT_M0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready[0] && trk_valid) |-> (req_dom[0] == 2'b00 && req_addr[0] != trk_addr)); // R7
    AST_NO_HAZARD_GRANT_M1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready[1] && trk_valid) |-> (req_dom[1] == 2'b00 && req_addr[1] != trk_addr)); // R8
    AST_SNOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((|snp_valid) && ((snp_valid & snp_ready) == 2'b00)) |=>
        (snp_valid == $past(snp_valid) && $stable(snp_addr) && $stable(snp_op))); // R11
    AST_ONE_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(snp_valid)); // R11
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid)); // R11
    AST_DIRTY_IMPLIES_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rsp_valid) && rsp_resp[3]) |-> rsp_resp[2]); // R4
endmodule

bind coh_ic coh_ic_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_dom   (req_dom),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_resp  (rsp_resp),
    .snp_valid (snp_valid),
    .snp_ready (snp_ready),
    .snp_op    (snp_op),
    .snp_addr  (snp_addr),
    .trk_valid (trk_valid),
    .trk_addr  (trk_addr)
);

// File: tb/coh_ic_bench.sv
module coh_ic_bench;
    localparam int            AW   = 4;
    localparam int            DW   = 32;
    localparam logic [DW-1:0] BASE = 32'hA5A5_0000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           req_valid = '0;
    logic [1:0]           req_ready;
    logic [1:0]           req_op = '0;
    logic [1:0][1:0]      req_dom = '0;
    logic [1:0][AW-1:0]   req_addr = '0;
    logic [1:0]           rsp_valid;
    logic [DW-1:0]        rsp_data;
    logic [3:0]           rsp_resp;
    logic [1:0]           rack = '0;
    logic [1:0]           wack = '0;
    logic [1:0]           snp_valid;
    logic [1:0]           snp_ready = '0;
    logic                 snp_op;
    logic [AW-1:0]        snp_addr;
    logic [1:0]           cr_valid = '0;
    logic [1:0]           cr_has_data = '0;
    logic [1:0]           cr_dirty = '0;
    logic [1:0][DW-1:0]   cd_data = '0;

    int checks = 0;
    int fails  = 0;
    int last_served = -1;

    always #4 clk = ~clk;

    coh_ic #(.AW(AW), .DW(DW), .MEM_BASE(BASE)) u_coh_ic (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_dom(req_dom), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_resp(rsp_resp),
        .rack(rack), .wack(wack),
        .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_op(snp_op), .snp_addr(snp_addr),
        .cr_valid(cr_valid), .cr_has_data(cr_has_data), .cr_dirty(cr_dirty), .cd_data(cd_data)
    );

    typedef struct packed {
        logic          mgr;
        logic          op;
        logic [1:0]    dom;
        logic [AW-1:0] addr;
        logic          has;
        logic          dirty;
        logic [DW-1:0] word;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'b01, 4'h2, 1'b1, 1'b0, 32'h1111_2222},
        '{1'b1, 1'b0, 2'b10, 4'h3, 1'b1, 1'b1, 32'h3333_4444},
        '{1'b0, 1'b0, 2'b11, 4'h4, 1'b0, 1'b0, 32'h0},
        '{1'b1, 1'b1, 2'b01, 4'h6, 1'b0, 1'b0, 32'h0},
        '{1'b0, 1'b0, 2'b00, 4'hF, 1'b0, 1'b0, 32'h0},
        '{1'b1, 1'b1, 2'b00, 4'h1, 1'b0, 1'b0, 32'h0}
    };

    function automatic logic [1:0] oh(input int i);
        return (i == 1) ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input int m, input logic op, input logic [1:0] dom,
                           input logic [AW-1:0] addr, input logic has, input logic dirty,
                           input logic [DW-1:0] word, input logic ack);
        int o = 1 - m;
        int n = 0;
        logic [DW-1:0] edata;
        logic [3:0]    eresp;
        string         tag;
        if (op) begin
            edata = '0; eresp = 4'b0000; tag = (dom == 2'b00) ? "R6" : "R2";
        end else if (dom == 2'b00) begin
            edata = BASE + DW'(addr); eresp = 4'b0000; tag = "R6";
        end else if (has) begin
            edata = word; eresp = {dirty, 1'b1, 2'b00}; tag = "R4";
        end else begin
            edata = BASE + DW'(addr); eresp = 4'b0000; tag = "R5";
        end
        @(negedge clk);
        req_valid[m] = 1'b1; req_op[m] = op; req_dom[m] = dom; req_addr[m] = addr;
        #1;
        while (!req_ready[m] && n < 200) begin
            @(negedge clk); #1; n++;
        end
        chk(req_ready[m], "R7 request never accepted", 32'(req_ready), 32'(oh(m)));
        @(posedge clk);
        @(negedge clk);
        req_valid[m] = 1'b0;
        if (dom == 2'b00) begin
            chk(snp_valid == 2'b00, "R6 snoop issued", 32'(snp_valid), 32'h0);
        end else begin
            chk(snp_valid == oh(o) && snp_op == op && snp_addr == addr,
                op ? "R2 snoop" : "R3 snoop", {snp_valid, snp_op, snp_addr},
                {2'(oh(o)), op, addr});
            @(negedge clk);
            chk(snp_valid == oh(o) && snp_addr == addr, "R11 snoop held",
                32'(snp_valid), 32'(oh(o)));
            snp_ready[o] = 1'b1;
            @(posedge clk);
            @(negedge clk);
            snp_ready[o] = 1'b0;
            chk(rsp_valid == 2'b00, "R2 response before snoop response", 32'(rsp_valid), 32'h0);
            cr_valid[o] = 1'b1; cr_has_data[o] = has; cr_dirty[o] = dirty; cd_data[o] = word;
            @(posedge clk);
            @(negedge clk);
            cr_valid[o] = 1'b0;
        end
        chk(rsp_valid == oh(m), {tag, " response strobe"}, 32'(rsp_valid), 32'(oh(m)));
        chk(rsp_data == edata, {tag, " data"}, rsp_data, edata);
        chk(rsp_resp == eresp, {tag, " resp"}, 32'(rsp_resp), 32'(eresp));
        last_served = m;
        if (ack) begin
            if (op) wack[m] = 1'b1; else rack[m] = 1'b1;
            @(negedge clk);
            wack[m] = 1'b0; rack[m] = 1'b0;
        end
    endtask

    task automatic arb_check();
        int p = (last_served == 0) ? 1 : 0;
        @(negedge clk);
        req_valid = 2'b11; req_dom = '0; req_op = 2'b00;
        #1;
        chk(req_ready == oh(p), "R9 priority", 32'(req_ready), 32'(oh(p)));
        req_valid = 2'b00;
    endtask

    task automatic stall_check(input string tag, input int m);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(!req_ready[m] && snp_valid == 2'b00, tag, {req_ready, snp_valid}, 32'h0);
        end
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(req_ready == 0 && rsp_valid == 0 && snp_valid == 0, "R1 reset outputs",
            {req_ready, rsp_valid, snp_valid}, 32'h0);
        arb_check();  // R9 manager 0 first after reset
        run_txn(0, 1'b0, 2'b00, 4'h0, 1'b0, 1'b0, '0, 1'b1);  // R1 store contents
        arb_check();  // R9 rotation
        for (int i = 0; i < NV; i++) begin
            run_txn(int'(VECS[i].mgr), VECS[i].op, VECS[i].dom, VECS[i].addr,
                    VECS[i].has, VECS[i].dirty, VECS[i].word, 1'b1);
        end
        arb_check();  // R9 rotation after table

        // R7 hazard: make-unique on line 5 left unacknowledged
        run_txn(0, 1'b1, 2'b01, 4'h5, 1'b0, 1'b0, '0, 1'b0);
        @(negedge clk);
        req_valid[1] = 1'b1; req_op[1] = 1'b0; req_dom[1] = 2'b01; req_addr[1] = 4'h5;
        stall_check("R7 same-line stall", 1);
        rack[0] = 1'b1; wack[1] = 1'b1;
        stall_check("R7 wrong acknowledge released stall", 1);
        rack[0] = 1'b0; wack[1] = 1'b0;
        req_addr[1] = 4'h9;
        stall_check("R8 shareable stall while tracked", 1);
        req_valid[1] = 1'b0;
        run_txn(1, 1'b0, 2'b00, 4'h7, 1'b0, 1'b0, '0, 1'b0);  // R8 private read proceeds
        @(negedge clk);
        wack[0] = 1'b1;
        @(negedge clk);
        wack[0] = 1'b0;
        // R7 released: read snoops the new owner, which returns dirty data
        run_txn(1, 1'b0, 2'b01, 4'h5, 1'b1, 1'b1, 32'hDEAD_BEEF, 1'b1);
        // R10 store still holds its reset word for line 5
        run_txn(0, 1'b0, 2'b00, 4'h5, 1'b0, 1'b0, '0, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule